// File: doc/BRIEF.md
# Bus Cycle Attribute Generator

This block sits between a core's internal request logic and its external bus. It takes one request at a time and plays it out as one or more external bus transfers. For each transfer it drives the address and write data, and three attribute indicators: cacheable, pseudo-lock and last-transfer. It also decides whether the transfers of a request run as a burst or as separate cycles. Operands of 64 bits are split asymmetrically. A 64-bit read is one request of two transfers, and the system picks burst or non-burst through the acknowledge it returns. A 64-bit write always goes out as two separate non-burst cycles, because only write-backs may burst. Line write-backs move four 32-bit words in ascending order.

The sequencer has three states. `ST_IDLE` waits for a request. `ST_ADDR` is the one-cycle address phase of a transfer. `ST_DATA` waits for an acknowledge. The transitions are:
- **accept**: `ST_IDLE` to `ST_ADDR`, taken when a legal request is offered.
- **phase**: `ST_ADDR` to `ST_DATA`, always taken.
- **burst-continue**: `ST_DATA` to `ST_DATA`, taken on burst-ready when the request may burst and transfers remain.
- **re-address**: `ST_DATA` to `ST_ADDR`, taken on any other acknowledge when transfers remain.
- **finish**: `ST_DATA` to `ST_IDLE`, taken on the acknowledge of the final transfer.

Top module: `buscyc_attr_gen`

## Requirements
- R1: While a transfer is in progress, `cache_o` is high for the following requests: cacheable data reads (kind 0), cacheable code fetches (kind 1), replacement write-backs (kind 5) and snoop write-backs (kind 6).
- R2: While a transfer is in progress, `cache_o` is low for the following requests: non-cacheable kinds 0 and 1, I/O (kind 2), special cycles (kind 3) and write-through writes (kind 4). When the block is idle, `cache_o` is low.
- R3: With `enh_mode` high when a request is accepted, `plock_o` stays low for the whole request. With `enh_mode` low, `plock_o` is high on every transfer of a 64-bit access and low on every other request.
- R4: A 64-bit read (kind 0 or 1 with `req_wide`) runs as two transfers at the 8-byte-aligned address and at that address plus 4. If the first transfer ends with `brdy`, the second follows with no new address phase. If it ends with `rdy`, the second gets its own address phase. `last_o` is high only on the second transfer.
- R5: A 64-bit write-through write (kind 4 with `req_wide`) runs as two transfers. Each transfer has its own address phase, even when it is acknowledged with `brdy`, and `last_o` is high on both.
- R6: A write-back (kind 5 or 6) runs as four 32-bit transfers. The addresses start at the 16-byte-aligned address and go up by 4 each time. `last_o` is high only on the fourth transfer. A transfer continues without a new address phase only after a `brdy`.
- R7: A transfer completes at a rising edge where `rdy` or `brdy` is high and the block is in its data phase. Acknowledges during the address phase or while idle have no effect.
- R8: Attributes, address, write data and `cyc_write` hold steady from the address phase until the transfer completes.
- R9: `req_accept` is high only while the block is idle and `req_valid` is high with a legal request. Two requests are refused, and start no transfer: kind 7, and write-backs offered while `enh_mode` is low.
- R10: `req_wide` widens only kinds 0, 1 and 4. All other kinds make one transfer at the 4-byte-aligned address. Transfer b drives `cyc_wdata = req_wdata[32*b +: 32]`, and `cyc_write` is high exactly for kinds 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 3 | Request type code |
| req_cacheable | input | 1 | Request is cacheable |
| req_wide | input | 1 | 64-bit operand |
| enh_mode | input | 1 | Enhanced (write-back) bus mode |
| req_addr | input | AW | Request byte address |
| req_wdata | input | 4*DW | Write data, word b in bits 32b+31..32b |
| rdy | input | 1 | Plain ready acknowledge |
| brdy | input | 1 | Burst-ready acknowledge |
| req_accept | output | 1 | Request taken this cycle |
| cyc_busy | output | 1 | Request in progress |
| cyc_ads | output | 1 | Address phase of a transfer |
| cyc_write | output | 1 | Transfer is a write |
| cyc_addr | output | AW | Transfer byte address |
| cyc_wdata | output | DW | Transfer write data |
| cache_o | output | 1 | Cacheable indicator |
| plock_o | output | 1 | Pseudo-lock indicator |
| last_o | output | 1 | Last-transfer indicator |

## Verification
The bench sweeps every request kind against both values of the cacheable, wide and enhanced-mode flags. It replays each combination under three acknowledge patterns: all plain ready, all burst-ready, and an alternating mix that also puts a stray ready in the address phase.

The mixed pattern catches three kinds of fault. A design that bursts a split 64-bit write would drop that write's second address phase. A design that ignores the acknowledge type would skip or add address phases in a write-back. A design that completes a transfer during its address phase would move the word address one step too early. Further checks compare the last-transfer flag on each transfer against the count that request should have. Refused requests must leave the block idle.

// File: rtl/buscyc_pkg.sv
package buscyc_pkg;
    localparam int unsigned LINE_BEATS = 4;
    localparam int unsigned BEAT_W     = $clog2(LINE_BEATS);

    typedef enum logic [2:0] {
        K_DRD  = 3'd0,
        K_CODE = 3'd1,
        K_IO   = 3'd2,
        K_SPEC = 3'd3,
        K_WTWR = 3'd4,
        K_RWB  = 3'd5,
        K_SWB  = 3'd6,
        K_RSVD = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              legal;
        logic              cache;
        logic              plock;
        logic              write;
        logic              burst_ok;
        logic              split_last;
        logic [BEAT_W-1:0] beats_m1;
    } attr_t;
endpackage

// File: rtl/buscyc_classify.sv
module buscyc_classify
    import buscyc_pkg::*;
(
    input  logic [2:0] kind_i,
    input  logic       cacheable_i,
    input  logic       wide_i,
    input  logic       enh_i,
    output attr_t      attr_o
);
    kind_e k;
    logic  is_rd, is_wb, wide_eff;

    assign k = kind_e'(kind_i);

    always_comb begin
        is_rd    = (k == K_DRD) || (k == K_CODE);
        is_wb    = (k == K_RWB) || (k == K_SWB);
        wide_eff = wide_i && (is_rd || (k == K_WTWR));

        attr_o.legal      = (k != K_RSVD) && !(is_wb && !enh_i);
        attr_o.cache      = (is_rd && cacheable_i) || is_wb;
        attr_o.plock      = !enh_i && wide_eff;
        attr_o.write      = (k == K_WTWR) || is_wb;
        attr_o.burst_ok   = is_wb || (is_rd && wide_eff);
        attr_o.split_last = wide_eff && (k == K_WTWR);
        if (is_wb)
            attr_o.beats_m1 = BEAT_W'(LINE_BEATS - 1);
        else if (wide_eff)
            attr_o.beats_m1 = BEAT_W'(1);
        else
            attr_o.beats_m1 = '0;
    end

    // R2
    always_comb begin
        io_no_cache_chk: assert (!(((k == K_IO) || (k == K_SPEC)) && attr_o.cache));
    end
endmodule

// File: rtl/buscyc_seq.sv
module buscyc_seq
    import buscyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BEAT_W-1:0] beats_m1_i,
    input  logic              burst_ok_i,
    input  logic              rdy_i,
    input  logic              brdy_i,
    output logic              busy_o,
    output logic              ads_o,
    output logic [BEAT_W-1:0] beat_o
);
    seq_state_e state, state_nx;
    logic [BEAT_W-1:0] beat, beat_nx;
    logic ack, final_beat;

    assign ack        = rdy_i || brdy_i;
    assign final_beat = (beat == beats_m1_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_nx;
            beat  <= beat_nx;
        end
    end

    always_comb begin
        state_nx = state;
        beat_nx  = beat;
        unique case (state)
            ST_IDLE: begin
                beat_nx = '0;
                if (start_i) state_nx = ST_ADDR;
            end
            ST_ADDR: state_nx = ST_DATA;
            ST_DATA: begin
                if (ack) begin
                    if (final_beat) begin
                        state_nx = ST_IDLE;
                        beat_nx  = '0;
                    end else begin
                        beat_nx  = beat + 1'b1;
                        state_nx = (brdy_i && burst_ok_i) ? ST_DATA : ST_ADDR;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o = (state != ST_IDLE);
        ads_o  = (state == ST_ADDR);
        beat_o = beat;
    end

    // R7
    addr_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |=> (state == ST_DATA));

    // R4
    burst_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && brdy_i && burst_ok_i && !final_beat) |=> (state == ST_DATA));

    // R5
    nonburst_readdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && ack && !burst_ok_i && !final_beat) |=> ads_o);

    // R6
    beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (beat <= beats_m1_i));
endmodule

// File: rtl/buscyc_attr_gen.sv
module buscyc_attr_gen
    import buscyc_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic                     req_cacheable,
    input  logic                     req_wide,
    input  logic                     enh_mode,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW*LINE_BEATS-1:0] req_wdata,
    input  logic                     rdy,
    input  logic                     brdy,
    output logic                     req_accept,
    output logic                     cyc_busy,
    output logic                     cyc_ads,
    output logic                     cyc_write,
    output logic [AW-1:0]            cyc_addr,
    output logic [DW-1:0]            cyc_wdata,
    output logic                     cache_o,
    output logic                     plock_o,
    output logic                     last_o
);
    localparam int unsigned OFS = $clog2(DW / 8);

    attr_t                     attr_in, cap;
    logic [AW-1:0]             cap_addr;
    logic [DW*LINE_BEATS-1:0]  cap_wdata;
    logic                      cap_enh;
    logic                      busy, start;
    logic [BEAT_W-1:0]         beat;
    logic [AW-1:0]             align;

    buscyc_classify cls_i (
        .kind_i      (req_kind),
        .cacheable_i (req_cacheable),
        .wide_i      (req_wide),
        .enh_i       (enh_mode),
        .attr_o      (attr_in)
    );

    assign start = !busy && req_valid && attr_in.legal;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap       <= '0;
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_enh   <= 1'b0;
        end else if (start) begin
            cap       <= attr_in;
            cap_addr  <= req_addr;
            cap_wdata <= req_wdata;
            cap_enh   <= enh_mode;
        end
    end

    buscyc_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .beats_m1_i (cap.beats_m1),
        .burst_ok_i (cap.burst_ok),
        .rdy_i      (rdy),
        .brdy_i     (brdy),
        .busy_o     (busy),
        .ads_o      (cyc_ads),
        .beat_o     (beat)
    );

    always_comb begin
        align      = (AW'(cap.beats_m1) << OFS) | AW'((1 << OFS) - 1);
        req_accept = start;
        cyc_busy   = busy;
        cyc_write  = busy && cap.write;
        cache_o    = busy && cap.cache;
        plock_o    = busy && cap.plock;
        last_o     = busy && (cap.split_last || (beat == cap.beats_m1));
        cyc_addr   = busy ? ((cap_addr & ~align) | (AW'(beat) << OFS)) : '0;
        cyc_wdata  = busy ? cap_wdata[beat*DW +: DW] : '0;
    end

    // R8
    attr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(!cyc_ads && (rdy || brdy))) |=>
        $stable({cache_o, plock_o, last_o, cyc_write, cyc_addr, cyc_wdata}));

    // R3
    plock_enh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cap_enh) |-> !plock_o);

    // R9
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req_valid && attr_in.legal)) |=> !cyc_busy);
endmodule

// File: tb/buscyc_attr_gen_tb_top.sv
module buscyc_attr_gen_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_cacheable, req_wide, enh_mode, rdy, brdy;
    logic [2:0]   req_kind;
    logic [31:0]  req_addr;
    logic [127:0] req_wdata;
    logic         req_accept, cyc_busy, cyc_ads, cyc_write, cache_o, plock_o, last_o;
    logic [31:0]  cyc_addr, cyc_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    buscyc_attr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_cacheable(req_cacheable), .req_wide(req_wide), .enh_mode(enh_mode),
        .req_addr(req_addr), .req_wdata(req_wdata), .rdy(rdy), .brdy(brdy),
        .req_accept(req_accept), .cyc_busy(cyc_busy), .cyc_ads(cyc_ads),
        .cyc_write(cyc_write), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
        .cache_o(cache_o), .plock_o(plock_o), .last_o(last_o)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic chk_attrs(input int k, input bit c, input bit e, input bit we,
                             input int b, input int beats, input logic [31:0] addr);
        bit is_rd = (k == 0) || (k == 1);
        bit is_wb = (k == 5) || (k == 6);
        bit exp_last = (k == 4 && we) ? 1'b1 : (b == beats - 1);
        logic [31:0] base = addr & ~(32'(beats * 4) - 32'd1);
        chk(((is_rd && c) || is_wb) ? "R1 cacheable" : "R2 noncacheable",
            32'(cache_o), 32'((is_rd && c) || is_wb));
        chk("R3 plock", 32'(plock_o), 32'(!e && we));
        chk(is_wb ? "R6 last" : (k == 4 && we) ? "R5 last" : "R4 last",
            32'(last_o), 32'(exp_last));
        chk("R6 R10 addr", cyc_addr, base + 32'(b * 4));
        chk("R10 write", 32'(cyc_write), 32'(k >= 4 && k <= 6));
        if (k >= 4 && k <= 6)
            chk("R10 wdata", cyc_wdata, req_wdata[b*32 +: 32]);
    endtask

    task automatic run_one(input int k, input bit c, input bit w, input bit e,
                           input int mode, input int idx);
        bit is_rd = (k == 0) || (k == 1);
        bit is_wb = (k == 5) || (k == 6);
        bit legal = (k != 7) && !(is_wb && !e);
        bit we = w && (is_rd || k == 4);
        bit bok = is_wb || (is_rd && we);
        int beats = is_wb ? 4 : we ? 2 : 1;
        bit prev_b = 0;
        @(negedge clk);
        req_kind = 3'(k); req_cacheable = c; req_wide = w; enh_mode = e;
        req_addr = 32'h2000_0000 + 32'(idx * 32'h54) + 32'h0C;
        for (int i = 0; i < 4; i++)
            req_wdata[i*32 +: 32] = 32'hC0DE_0000 | 32'(idx << 4) | 32'(i);
        req_valid = 1'b1;
        #1 chk("R9 accept", 32'(req_accept), 32'(legal));
        @(negedge clk);
        req_valid = 1'b0;
        enh_mode = ~e;
        if (!legal) begin
            chk("R9 refused stays idle", 32'(cyc_busy), 32'd0);
            return;
        end
        for (int b = 0; b < beats; b++) begin
            bit use_b = (mode == 1) || (mode == 2 && (b % 2 == 0));
            if (b == 0 || !(bok && prev_b)) begin
                chk(is_wb ? "R6 addr phase" : (k == 4) ? "R5 addr phase" : "R4 addr phase",
                    32'(cyc_ads), 32'd1);
                chk_attrs(k, c, e, we, b, beats, req_addr);
                if (mode == 2) rdy = 1'b1;
                @(negedge clk);
                rdy = 1'b0;
            end else begin
                chk(is_wb ? "R6 burst no addr phase" : "R4 burst no addr phase",
                    32'(cyc_ads), 32'd0);
            end
            chk("R7 data phase", 32'(cyc_busy && !cyc_ads), 32'd1);
            chk_attrs(k, c, e, we, b, beats, req_addr);
            if (mode == 0) begin
                @(negedge clk);
                chk("R8 hold while waiting", 32'(cyc_busy && !cyc_ads), 32'd1);
                chk_attrs(k, c, e, we, b, beats, req_addr);
            end
            if (use_b) brdy = 1'b1; else rdy = 1'b1;
            @(negedge clk);
            rdy = 1'b0; brdy = 1'b0;
            prev_b = use_b;
        end
        chk("R7 idle after final", 32'(cyc_busy), 32'd0);
        chk("R2 idle cache low", 32'(cache_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int idx = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_cacheable = 1'b0;
        req_wide = 1'b0; enh_mode = 1'b1; req_addr = '0; req_wdata = '0;
        rdy = 1'b0; brdy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset cache", 32'(cache_o), 32'd0);
        chk("R3 reset plock", 32'(plock_o), 32'd0);
        chk("R7 reset idle", 32'({cyc_busy, cyc_ads, last_o}), 32'd0);
        // R7: stray acknowledges while idle start nothing
        rdy = 1'b1; brdy = 1'b1;
        @(negedge clk);
        chk("R7 idle ack ignored", 32'(cyc_busy), 32'd0);
        rdy = 1'b0; brdy = 1'b0;
        for (int mode = 0; mode < 3; mode++)
            for (int e = 0; e < 2; e++)
                for (int w = 0; w < 2; w++)
                    for (int c = 0; c < 2; c++)
                        for (int k = 0; k < 8; k++) begin
                            run_one(k, c[0], w[0], e[0], mode, idx);
                            idx++;
                        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule